// File: doc/BRIEF.md
# 4B/5B Nibble Coder for a 100 Mb/s Coding Sublayer

This block sits between a media access controller's nibble-wide transmit and receive paths and a 5-bit symbol stream that is already aligned. On the transmit side it turns a frame into code groups. It marks the start of the frame with the two-symbol start delimiter, encodes every following nibble, and puts the error symbol in place of any nibble flagged as bad. When the frame ends it closes it with the two-symbol end delimiter. It sends the idle symbol between frames. The start delimiter takes the place of the first two nibbles of the frame, which are preamble.

On the receive side it finds the start delimiter in the incoming symbols and decodes the symbols that follow into nibbles with a valid flag. It raises an error flag for symbols that are not legal inside a frame, for a frame that is cut off by idle, and for a start delimiter that is badly formed (false carrier). A frame ends cleanly on the end delimiter. When the link-error report is enabled, an external link-fault indication is signalled as a special nibble with the error flag. A bypass input turns off the coding in both directions, so raw 5-bit groups pass through. In bypass, a bad start delimiter is reported with a dedicated 5-bit marker.

Top module: `pcs_coder`

## Requirements
- R1: While reset is held, tx_code is 11111 (idle), rx_dv and rx_er are 0 and rxd is 00000.
- R2: With bypass low and no frame in progress, tx_code is the idle symbol 11111 on every cycle.
- R3: If tx_en is sampled high at clock edge k with the encoder idle, tx_code is J=11000 after edge k and K=10001 after edge k+1. From edge k+2 on, it carries the code of the nibble sampled at that edge. The nibbles sampled at k and k+1 are not sent.
- R4: Nibbles map to codes as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. With bypass low, tx_code only ever carries one of these codes, 11111, J, K, T, R or HALT.
- R5: Within a frame, a cycle with tx_en and tx_er both high sends HALT=00100 in place of the nibble.
- R6: When tx_en is sampled low during a frame, tx_code is T=01101 after that edge, then R=00111, then idle.
- R7: With bypass high, tx_code is the txd[4:0] value from the previous edge, and rxd[4:0] is the rx_code value from the previous edge. The only exceptions are the R11 marker and the R12 report.
- R8: On receive, after J then K, each data code gives rx_dv=1, rx_er=0 and rxd[3:0]=its nibble on the next cycle, with rxd[4]=0 when not in bypass.
- R9: Inside a received frame, a code that is not a data code, idle or T gives rx_dv=1 and rx_er=1 for that cycle (bypass low). The frame continues.
- R10: A received T gives rx_dv=0 from its cycle on, and the frame ends. Idle arriving inside a frame before T gives rx_dv=1 with rx_er=1 for one cycle (bypass low), then rx_dv=0.
- R11: If J is followed by anything other than K, each cycle up to the next idle reports false carrier. With bypass low the report is rx_dv=0, rx_er=1, rxd=01110. With bypass high it is rx_dv=0, rx_er=0, rxd=11110.
- R12: With link_fault high and link_err_rpt_en high, the next cycle shows rx_dv=0, rx_er=1, rxd=00011. With link_err_rpt_en low, it shows rx_dv=0 and rx_er=0. In both cases any received frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | Pass raw 5-bit groups through both directions |
| link_err_rpt_en | input | 1 | Enables signalling of link faults on the receive side |
| link_fault | input | 1 | Link fault indication from the receive path |
| tx_en | input | 1 | Transmit frame enable |
| tx_er | input | 1 | Transmit error, replaces the nibble by HALT |
| txd | input | 5 | Transmit nibble in [3:0]; full 5-bit group in bypass |
| tx_code | output | 5 | Transmitted code group |
| rx_code | input | 5 | Received aligned code group |
| rx_dv | output | 1 | Received data valid |
| rx_er | output | 1 | Received error |
| rxd | output | 5 | Received nibble in [3:0]; full 5-bit group in bypass |

## Verification
The embedded properties rely on several properties of the inputs. Bypass must stay steady for a few cycles around any checked transmit event, because switching it resets the encoder's framing. Reset must not be asserted partway through a frame. The inputs must be synchronous to clk. The stimulus meets these conditions. It changes inputs only on the falling edge and changes bypass only between frames while the line is idle. It keeps tx_en high for at least three cycles in every frame and leaves at least two idle cycles between frames. The false-carrier and link-fault cases are driven from a known idle receive state, so each expected output follows from a single defined path.

// File: rtl/pcs_coder_pkg.sv
// Package: shared widths, code-group constants, state types and the
// nibble/code mapping functions used by both directions of the coder.
// Assumes the 5-bit stream is already symbol aligned.
package pcs_coder_pkg;

    localparam int NIB_W  = 4;
    localparam int CODE_W = NIB_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NIB_W-1:0]  nib_t;

    localparam code_t C_IDLE      = 5'b11111;
    localparam code_t C_SSD_J     = 5'b11000;
    localparam code_t C_SSD_K     = 5'b10001;
    localparam code_t C_ESD_T     = 5'b01101;
    localparam code_t C_ESD_R     = 5'b00111;
    localparam code_t C_HALT      = 5'b00100;
    localparam code_t C_FALSE_BYP = 5'b11110;

    localparam nib_t N_FALSE_CAR = 4'b1110;
    localparam nib_t N_LINK_ERR  = 4'b0011;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND_K,
        TX_DATA,
        TX_SEND_R
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_GOT_J,
        RX_DATA,
        RX_GOT_T,
        RX_FALSE
    } rx_st_e;

    typedef struct packed {
        logic valid;
        nib_t nib;
    } dec_t;

    // Nibble to data code group.
    function automatic code_t nib_to_code(input nib_t n);
        code_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

    // Data code group back to nibble, flagged when not a data code.
    function automatic dec_t code_to_nib(input code_t c);
        dec_t d;
        d.valid = 1'b1;
        case (c)
            5'b11110: d.nib = 4'h0;
            5'b01001: d.nib = 4'h1;
            5'b10100: d.nib = 4'h2;
            5'b10101: d.nib = 4'h3;
            5'b01010: d.nib = 4'h4;
            5'b01011: d.nib = 4'h5;
            5'b01110: d.nib = 4'h6;
            5'b01111: d.nib = 4'h7;
            5'b10010: d.nib = 4'h8;
            5'b10011: d.nib = 4'h9;
            5'b10110: d.nib = 4'hA;
            5'b10111: d.nib = 4'hB;
            5'b11010: d.nib = 4'hC;
            5'b11011: d.nib = 4'hD;
            5'b11100: d.nib = 4'hE;
            5'b11101: d.nib = 4'hF;
            default: begin
                d.valid = 1'b0;
                d.nib   = '0;
            end
        endcase
        return d;
    endfunction

    // True for every group the encoder may legally emit.
    function automatic logic is_tx_legal(input code_t c);
        dec_t d;
        d = code_to_nib(c);
        return d.valid || (c == C_IDLE) || (c == C_SSD_J) || (c == C_SSD_K) ||
               (c == C_ESD_T) || (c == C_ESD_R) || (c == C_HALT);
    endfunction

endpackage

// File: rtl/pcs_tx_encoder.sv
// Transmit half: frames MII nibbles into 5-bit code groups.
// A frame opens with J,K in place of the first two nibbles, carries one
// code per cycle, substitutes HALT on tx_er and closes with T,R.
// Assumes tx_en stays high for at least three cycles per frame.
// Bypass forwards txd[4:0] and returns the framing state to idle.
module pcs_tx_encoder
    import pcs_coder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [CODE_W-1:0] txd,
    output logic [CODE_W-1:0] tx_code
);

    tx_st_e st_q, st_d;
    code_t  code_q, code_d;

    // Next framing state and next code group.
    always_comb begin
        st_d   = st_q;
        code_d = C_IDLE;
        if (bypass) begin
            st_d   = TX_IDLE;
            code_d = txd;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    if (tx_en) begin
                        code_d = C_SSD_J;
                        st_d   = TX_SEND_K;
                    end
                end
                TX_SEND_K: begin
                    code_d = C_SSD_K;
                    st_d   = TX_DATA;
                end
                TX_DATA: begin
                    if (!tx_en) begin
                        code_d = C_ESD_T;
                        st_d   = TX_SEND_R;
                    end else if (tx_er) begin
                        code_d = C_HALT;
                    end else begin
                        code_d = nib_to_code(txd[NIB_W-1:0]);
                    end
                end
                TX_SEND_R: begin
                    code_d = C_ESD_R;
                    st_d   = TX_IDLE;
                end
                default: st_d = TX_IDLE;
            endcase
        end
    end

    // State and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            code_q <= C_IDLE;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    assign tx_code = code_q;

    assert_j_then_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_code == C_SSD_J && !bypass && $past(!bypass)) |=> (tx_code == C_SSD_K));

    assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bypass) |-> is_tx_legal(tx_code));

    assert_halt_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_er && !bypass &&
         $past(tx_en) && $past(tx_en, 2) && $past(tx_en, 3) &&
         $past(!bypass) && $past(!bypass, 2) && $past(!bypass, 3) &&
         $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
        |=> (tx_code == C_HALT));

    assert_t_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_code == C_ESD_T && !bypass && $past(!bypass)) |=> (tx_code == C_ESD_R));

endmodule

// File: rtl/pcs_rx_decoder.sv
// Receive half: finds J,K in an aligned symbol stream, decodes data
// codes into nibbles and reports bad symbols, aborted frames, false
// carrier and (when enabled) link faults. All outputs are registered:
// the group sampled at an edge is reflected on the ports after it.
// Assumes link_fault is synchronous to clk.
module pcs_rx_decoder
    import pcs_coder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              link_err_rpt_en,
    input  logic              link_fault,
    input  logic [CODE_W-1:0] rx_code,
    output logic              rx_dv,
    output logic              rx_er,
    output logic [CODE_W-1:0] rxd
);

    rx_st_e st_q, st_d;
    logic   dv_q, dv_d;
    logic   er_q, er_d;
    code_t  rxd_q, rxd_d;
    dec_t   dec;
    code_t  quiet_rxd;

    // Decode of the current group and the value shown outside a frame.
    always_comb begin
        dec       = code_to_nib(rx_code);
        quiet_rxd = bypass ? rx_code : '0;
    end

    // Framing state and output selection.
    always_comb begin
        st_d  = st_q;
        dv_d  = 1'b0;
        er_d  = 1'b0;
        rxd_d = quiet_rxd;
        if (link_fault) begin
            st_d = RX_IDLE;
            if (link_err_rpt_en) begin
                er_d  = 1'b1;
                rxd_d = {1'b0, N_LINK_ERR};
            end
        end else begin
            case (st_q)
                RX_IDLE: begin
                    if (rx_code == C_SSD_J) st_d = RX_GOT_J;
                end
                RX_GOT_J, RX_FALSE: begin
                    if ((st_q == RX_GOT_J && rx_code == C_SSD_K) ||
                        (st_q == RX_FALSE && rx_code == C_IDLE)) begin
                        st_d = (st_q == RX_GOT_J) ? RX_DATA : RX_IDLE;
                    end else begin
                        st_d = RX_FALSE;
                        if (bypass) begin
                            rxd_d = C_FALSE_BYP;
                        end else begin
                            er_d  = 1'b1;
                            rxd_d = {1'b0, N_FALSE_CAR};
                        end
                    end
                end
                RX_DATA: begin
                    if (rx_code == C_ESD_T) begin
                        st_d = RX_GOT_T;
                    end else if (rx_code == C_IDLE) begin
                        st_d = RX_IDLE;
                        dv_d = !bypass;
                        er_d = !bypass;
                    end else if (dec.valid) begin
                        dv_d  = 1'b1;
                        rxd_d = bypass ? rx_code : {1'b0, dec.nib};
                    end else begin
                        dv_d = 1'b1;
                        er_d = !bypass;
                    end
                end
                RX_GOT_T: st_d = RX_IDLE;
                default:  st_d = RX_IDLE;
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            dv_q  <= 1'b0;
            er_q  <= 1'b0;
            rxd_q <= '0;
        end else begin
            st_q  <= st_d;
            dv_q  <= dv_d;
            er_q  <= er_d;
            rxd_q <= rxd_d;
        end
    end

    assign rx_dv = dv_q;
    assign rx_er = er_q;
    assign rxd   = rxd_q;

    assert_ctrl_not_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !link_fault &&
         (rx_code == C_SSD_J || rx_code == C_SSD_K || rx_code == C_ESD_R || rx_code == C_HALT))
        |=> !(rx_dv && !rx_er));

    assert_idle_not_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !link_fault && rx_code == C_IDLE) |=> (!rx_dv || rx_er));

    assert_link_report_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fault && link_err_rpt_en) |=> (rx_er && !rx_dv && rxd == 5'b00011));

    assert_link_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fault && !link_err_rpt_en) |=> (!rx_er && !rx_dv));

endmodule

// File: rtl/pcs_coder.sv
// Top: 4B/5B coder with independent transmit and receive halves that
// share only the bypass control. No buffering at the edges; each half
// adds one register stage.
module pcs_coder
    import pcs_coder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              link_err_rpt_en,
    input  logic              link_fault,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [CODE_W-1:0] txd,
    output logic [CODE_W-1:0] tx_code,
    input  logic [CODE_W-1:0] rx_code,
    output logic              rx_dv,
    output logic              rx_er,
    output logic [CODE_W-1:0] rxd
);

    pcs_tx_encoder u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (bypass),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .txd     (txd),
        .tx_code (tx_code)
    );

    pcs_rx_decoder u_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .bypass          (bypass),
        .link_err_rpt_en (link_err_rpt_en),
        .link_fault      (link_fault),
        .rx_code         (rx_code),
        .rx_dv           (rx_dv),
        .rx_er           (rx_er),
        .rxd             (rxd)
    );

endmodule

// File: tb/pcs_coder_tb.sv
// Directed bench: one task per scenario; inputs change on the falling
// edge, outputs are compared on the next falling edge.
module pcs_coder_tb;

    localparam logic [4:0] I_C = 5'b11111, J_C = 5'b11000, K_C = 5'b10001;
    localparam logic [4:0] T_C = 5'b01101, R_C = 5'b00111, H_C = 5'b00100;
    localparam logic [4:0] ENC [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                        5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                        5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                        5'b11010, 5'b11011, 5'b11100, 5'b11101};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0, link_err_rpt_en = 1'b0, link_fault = 1'b0;
    logic tx_en = 1'b0, tx_er = 1'b0;
    logic [4:0] txd = '0;
    logic [4:0] tx_code, rx_code, rxd;
    logic [4:0] rx_drv = 5'b11111;
    logic rx_dv, rx_er;
    logic loop = 1'b0;
    logic collect = 1'b0;
    logic [3:0] got_q[$];
    int got_err = 0;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    assign rx_code = loop ? tx_code : rx_drv;

    pcs_coder u_dut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .link_err_rpt_en(link_err_rpt_en), .link_fault(link_fault),
        .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .tx_code(tx_code),
        .rx_code(rx_code), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd)
    );

    // Records decoded nibbles during the round-trip test.
    always @(negedge clk) begin
        if (collect && rx_dv) begin
            got_q.push_back(rxd[3:0]);
            if (rx_er) got_err++;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_rx(input logic dv, input logic er, input logic [4:0] d, input string what);
        chk({7'd0, rx_dv}, {7'd0, dv}, {what, " rx_dv"});
        chk({7'd0, rx_er}, {7'd0, er}, {what, " rx_er"});
        chk({3'd0, rxd}, {3'd0, d}, {what, " rxd"});
    endtask

    // Drive one received group, then compare the registered outputs.
    task automatic rx_step(input logic [4:0] c, input logic dv, input logic er,
                           input logic [4:0] d, input string what);
        rx_drv = c;
        @(negedge clk);
        chk_rx(dv, er, d, what);
    endtask

    // Sends an n-nibble frame; nibble i is base+5*i; tx_er on index er_idx.
    task automatic tx_frame(input int n, input int base, input int er_idx, input string tag);
        logic [4:0] exp_q[$];
        for (int i = 0; i < n; i++) begin
            logic [3:0] nb;
            @(negedge clk);
            if (exp_q.size() > 0) chk({3'd0, tx_code}, {3'd0, exp_q.pop_front()}, tag);
            nb = 4'(base + 5 * i);
            tx_en = 1'b1;
            tx_er = (i == er_idx);
            txd = {1'b0, nb};
            if (i == 0) exp_q.push_back(J_C);
            else if (i == 1) exp_q.push_back(K_C);
            else if (i == er_idx) exp_q.push_back(H_C);
            else exp_q.push_back(ENC[nb]);
        end
        @(negedge clk);
        chk({3'd0, tx_code}, {3'd0, exp_q.pop_front()}, tag);
        tx_en = 1'b0;
        tx_er = 1'b0;
        @(negedge clk);
        chk({3'd0, tx_code}, {3'd0, T_C}, {tag, " R6 end T"});
        @(negedge clk);
        chk({3'd0, tx_code}, {3'd0, R_C}, {tag, " R6 end R"});
        @(negedge clk);
        chk({3'd0, tx_code}, {3'd0, I_C}, {tag, " R6 back to idle"});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({3'd0, tx_code}, {3'd0, I_C}, "R1 tx_code in reset");
        chk_rx(1'b0, 1'b0, 5'd0, "R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        repeat (3) begin
            @(negedge clk);
            chk({3'd0, tx_code}, {3'd0, I_C}, "R2 idle");
        end
    endtask

    task automatic t_tx_frames();
        tx_frame(18, 0, -1, "R3 R4 full map frame");
        tx_frame(6, 3, 3, "R5 halt frame");
    endtask

    task automatic t_rx_frame();
        rx_step(I_C, 0, 0, 5'd0, "R8 pre idle");
        rx_step(J_C, 0, 0, 5'd0, "R8 J");
        rx_step(K_C, 0, 0, 5'd0, "R8 K");
        rx_step(5'b10100, 1, 0, 5'h2, "R8 data 2");
        rx_step(5'b11110, 1, 0, 5'h0, "R8 data 0");
        rx_step(5'b11101, 1, 0, 5'hF, "R8 data F");
        rx_step(T_C, 0, 0, 5'd0, "R10 T ends frame");
        rx_step(R_C, 0, 0, 5'd0, "R10 R");
        rx_step(I_C, 0, 0, 5'd0, "R10 idle after");
    endtask

    task automatic t_rx_errors();
        rx_step(J_C, 0, 0, 5'd0, "R9 J");
        rx_step(K_C, 0, 0, 5'd0, "R9 K");
        rx_step(H_C, 1, 1, 5'd0, "R9 halt in frame");
        rx_step(5'b01001, 1, 0, 5'h1, "R9 frame continues");
        rx_step(I_C, 1, 1, 5'd0, "R10 abort on idle");
        rx_step(I_C, 0, 0, 5'd0, "R10 after abort");
        rx_step(J_C, 0, 0, 5'd0, "R11 J");
        rx_step(5'b10100, 0, 1, 5'b01110, "R11 false carrier");
        rx_step(5'b01010, 0, 1, 5'b01110, "R11 false carrier holds");
        rx_step(I_C, 0, 0, 5'd0, "R11 cleared by idle");
    endtask

    task automatic t_link();
        link_err_rpt_en = 1'b1;
        link_fault = 1'b1;
        rx_step(I_C, 0, 1, 5'b00011, "R12 link report");
        link_fault = 1'b0;
        rx_step(J_C, 0, 0, 5'd0, "R12 J");
        rx_step(K_C, 0, 0, 5'd0, "R12 K");
        rx_step(5'b01011, 1, 0, 5'h5, "R12 data");
        link_fault = 1'b1;
        rx_step(5'b01011, 0, 1, 5'b00011, "R12 report in frame");
        link_fault = 1'b0;
        rx_step(5'b01011, 0, 0, 5'd0, "R12 frame dropped");
        link_err_rpt_en = 1'b0;
        link_fault = 1'b1;
        rx_step(I_C, 0, 0, 5'd0, "R12 not reported");
        link_fault = 1'b0;
        rx_step(I_C, 0, 0, 5'd0, "R12 quiet");
    endtask

    task automatic t_bypass();
        bypass = 1'b1;
        txd = 5'b01100;
        rx_step(5'b00010, 0, 0, 5'b00010, "R7 bypass rx raw");
        chk({3'd0, tx_code}, {3'd0, 5'b01100}, "R7 bypass tx raw");
        txd = 5'b10011;
        rx_step(J_C, 0, 0, J_C, "R7 bypass J");
        chk({3'd0, tx_code}, {3'd0, 5'b10011}, "R7 bypass tx raw 2");
        rx_step(K_C, 0, 0, K_C, "R7 bypass K");
        rx_step(5'b10100, 1, 0, 5'b10100, "R7 bypass data");
        rx_step(T_C, 0, 0, T_C, "R7 bypass T");
        rx_step(I_C, 0, 0, I_C, "R7 bypass idle");
        rx_step(J_C, 0, 0, J_C, "R11 bypass J");
        rx_step(5'b10100, 0, 0, 5'b11110, "R11 bypass bad start");
        rx_step(I_C, 0, 0, I_C, "R11 bypass idle");
        txd = 5'd0;
        bypass = 1'b0;
        rx_step(I_C, 0, 0, 5'd0, "R7 bypass off");
    endtask

    task automatic t_round_trip();
        int n;
        n = 10;
        @(negedge clk);
        got_q.delete();
        got_err = 0;
        loop = 1'b1;
        collect = 1'b1;
        tx_frame(n, 7, -1, "R3 round trip tx");
        repeat (2) @(negedge clk);
        collect = 1'b0;
        loop = 1'b0;
        chk(8'(got_q.size()), 8'(n - 2), "R8 round trip count");
        chk(8'(got_err), 8'd0, "R8 round trip errors");
        for (int i = 2; i < n; i++) begin
            logic [3:0] g;
            g = (got_q.size() > 0) ? got_q.pop_front() : 4'hx;
            chk({4'd0, g}, {4'd0, 4'(7 + 5 * i)}, "R8 round trip nibble");
        end
    endtask

    initial begin
        t_reset();
        t_idle();
        t_tx_frames();
        t_rx_frame();
        t_rx_errors();
        t_link();
        t_bypass();
        t_round_trip();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule